// File: doc/BRIEF.md
# Multichannel Simultaneous-Sampling Conversion Sequencer

This block is the digital control side of an eight-channel simultaneous-sampling converter. Software selects which channels take part through a channel-enable mask that is written over a small parallel bus with an active-low select and an active-low write strobe. A rising edge on the active-low convert request starts a sequence. The block then hands out one result slot for each enabled channel, lowest index first. Each slot is marked by a one-clock low pulse on the per-result ready flag. The final slot also drives the all-done flag low.

Everything runs on the conversion clock. The bus and convert inputs are sampled on that clock, and their edges are found by comparing each sample with the one before it. Result words come from a stand-in generator: the channel index sits in the upper bits and the sequence count in the lower bits. A bench can therefore tell every result apart. A shutdown input holds the sequencer quiet and leaves the mask unchanged.

Top module: `mcs_sequencer`

## Requirements
- R1: After reset, `eoc_n` and `eolc_n` are 1, `res_data` and `res_chan` are 0, and the mask is 0.
- R2: A mask write takes effect at a clock edge where `wr_n` is sampled 1, the previous sample of `wr_n` was 0, and `cs_n` is 0. Bit n of `din` set to 1 enables channel n. When `cs_n` is 1, the write is ignored.
- R3: A write may land at any time. A sequence uses the mask value held just before its start edge, so a write on that same edge, or during the sequence, only affects later sequences.
- R4: The start edge is a clock edge where `conv_n` is sampled 1 and its previous sample was 0. The first result comes on the 17th edge after the start edge and each later result 3 edges after the one before. Channels come in ascending index order, and disabled channels take no slot.
- R5: For each result, `eoc_n` is 0 for exactly one clock. On that same edge `res_chan` is set to the channel index and `res_data` to {channel[2:0], run[10:0]}. Here run counts accepted starts since reset, and the first start gives run 1.
- R6: `eolc_n` goes to 0 on the edge of the last enabled channel's result. When the mask is 0, `eolc_n` goes to 0 on the start edge itself and no `eoc_n` pulse follows.
- R7: Once low, `eolc_n` stays 0 until a clock edge where `conv_n` is sampled 0 and its previous sample was 1. On that edge it returns to 1.
- R8: If `conv_n` falls while a sequence is running, the sequence is abandoned and no further results are flagged.
- R9: While `shdn` is 1, start edges are ignored, a running sequence is abandoned, and no `eoc_n` pulse occurs. The mask keeps its value through shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shdn | input | 1 | Shutdown, active high |
| cs_n | input | 1 | Bus select, active low |
| wr_n | input | 1 | Write strobe, active low; captured on its rising edge |
| din | input | 8 | Channel-enable mask from the bus |
| conv_n | input | 1 | Convert request; low while sampling, rising edge starts a sequence |
| eoc_n | output | 1 | Result-ready pulse, active low |
| eolc_n | output | 1 | Last-result flag, active low |
| res_data | output | 14 | Result word of the latest slot |
| res_chan | output | 3 | Channel index of the latest slot |

## Verification
A mask write and a convert start can fall on the same clock edge. In that case the start must take the mask value from before the write. The bench provokes this by releasing `wr_n` and raising `conv_n` at the same instant, so that both are sampled on one edge. It then judges the result by the channel indices and words that follow, which must match the old mask. A follow-up run must show the new mask.

// File: rtl/mcs_sequencer.sv
module mcs_sequencer #(
  parameter int NCH   = 8,
  parameter int DW    = 14,
  parameter int FIRST = 17,
  parameter int GAP   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shdn,
  input  logic                   cs_n,
  input  logic                   wr_n,
  input  logic [NCH-1:0]         din,
  input  logic                   conv_n,
  output logic                   eoc_n,
  output logic                   eolc_n,
  output logic [DW-1:0]          res_data,
  output logic [$clog2(NCH)-1:0] res_chan
);
  localparam int CW = $clog2(NCH);
  localparam int TW = $clog2(FIRST);
  localparam int RW = DW - CW;

  logic [NCH-1:0] cfg, pend, pend_rest;
  logic           wr_q, conv_q, busy;
  logic [TW-1:0]  tmr;
  logic [RW-1:0]  run;
  logic [CW-1:0]  low_idx;

  wire wr_edge   = !cs_n && wr_n && !wr_q;
  wire conv_rise = conv_n && !conv_q;
  wire conv_fall = !conv_n && conv_q;
  wire start     = conv_rise && !shdn;

  assign pend_rest = pend & (pend - 1'b1);

  always_comb begin
    low_idx = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) low_idx = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      pend     <= '0;
      wr_q     <= 1'b1;
      conv_q   <= 1'b1;
      busy     <= 1'b0;
      tmr      <= '0;
      run      <= '0;
      eoc_n    <= 1'b1;
      eolc_n   <= 1'b1;
      res_data <= '0;
      res_chan <= '0;
    end else begin
      wr_q   <= wr_n;
      conv_q <= conv_n;
      eoc_n  <= 1'b1;
      if (wr_edge) cfg <= din;
      if (conv_fall) eolc_n <= 1'b1;
      if (shdn || conv_fall) begin
        busy <= 1'b0;
      end else if (start) begin
        run  <= run + 1'b1;
        pend <= cfg;
        tmr  <= TW'(FIRST - 1);
        busy <= |cfg;
        if (cfg == '0) eolc_n <= 1'b0;
      end else if (busy) begin
        if (tmr == '0) begin
          eoc_n    <= 1'b0;
          res_chan <= low_idx;
          res_data <= {low_idx, run};
          pend     <= pend_rest;
          tmr      <= TW'(GAP - 1);
          if (pend_rest == '0) begin
            busy   <= 1'b0;
            eolc_n <= 1'b0;
          end
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mcs_sequencer_chk.sv
module mcs_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic shdn,
  input logic conv_n,
  input logic eoc_n,
  input logic eolc_n
);
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |=> eoc_n); // R5
  AST_EOC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |=> eoc_n ##1 eoc_n); // R4
  AST_EOLC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eolc_n && conv_n |=> !eolc_n); // R7
  AST_EOLC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eolc_n) |-> $past(!conv_n)); // R7
  AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> eoc_n); // R9
endmodule

bind mcs_sequencer mcs_sequencer_chk u_chk (.*);

// File: tb/mcs_sequencer_tb.sv
module mcs_sequencer_tb;
  logic clk = 0, rst_n = 0, shdn = 0, cs_n = 1, wr_n = 1, conv_n = 1;
  logic [7:0] din = '0;
  logic eoc_n, eolc_n;
  logic [13:0] res_data;
  logic [2:0] res_chan;
  int checks = 0, errors = 0, run = 0;

  mcs_sequencer u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] m, input bit sel);
    @(negedge clk); cs_n = !sel; wr_n = 0; din = m;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic do_start();
    @(negedge clk); conv_n = 0;
    @(negedge clk); conv_n = 1;
    @(posedge clk); #1;
    if (!shdn) run++;
  endtask

  task automatic quiet(input int n, input string req);
    int low = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (!eoc_n) low++;
    end
    chk(low == 0, req, low, 0);
  endtask

  task automatic expect_seq(input logic [7:0] m, input string req);
    int n = $countones(m), idx = 0, ch = 0, stray = 0, last;
    if (n == 0) begin
      chk(eolc_n == 0, "R6 empty mask eolc", eolc_n, 0);
      quiet(40, "R6 empty mask no eoc");
      return;
    end
    last = 17 + 3 * (n - 1);
    for (int k = 1; k <= last + 2; k++) begin
      @(posedge clk); #1;
      if (idx < n && k == 17 + 3 * idx) begin
        while (!m[ch]) ch++;
        chk(eoc_n == 0, req, eoc_n, 0);
        chk(res_chan == 3'(ch), {req, " chan"}, res_chan, ch);
        chk(res_data == {3'(ch), 11'(run)}, {req, " data R5"}, res_data, {3'(ch), 11'(run)});
        chk(eolc_n == (idx != n - 1), {req, " eolc R6"}, eolc_n, idx != n - 1);
        idx++; ch++;
      end else if (!eoc_n) stray++;
    end
    chk(stray == 0, {req, " stray eoc R4"}, stray, 0);
  endtask

  task automatic t_reset();
    chk(eoc_n == 1 && eolc_n == 1, "R1 flags", {eoc_n, eolc_n}, 3);
    chk(res_data == 0 && res_chan == 0, "R1 result", res_data, 0);
    do_start();
    expect_seq(8'h00, "R1 mask zero");
  endtask

  task automatic t_full();
    write_cfg(8'hFF, 1);
    do_start();
    chk(eolc_n == 1, "R7 eolc released by conv fall", eolc_n, 1);
    expect_seq(8'hFF, "R4 full mask");
  endtask

  task automatic t_sparse();
    write_cfg(8'h25, 1);
    do_start();
    expect_seq(8'h25, "R2 sparse mask");
    repeat (10) @(posedge clk);
    #1 chk(eolc_n == 0, "R7 eolc held", eolc_n, 0);
  endtask

  task automatic t_midwrite();
    write_cfg(8'h81, 1);
    do_start();
    fork
      expect_seq(8'h81, "R3 old mask during write");
      begin repeat (5) @(posedge clk); write_cfg(8'h12, 1); end
    join
    do_start();
    expect_seq(8'h12, "R3 new mask next run");
  endtask

  task automatic t_nocs();
    write_cfg(8'hFF, 0);
    do_start();
    expect_seq(8'h12, "R2 write without select ignored");
  endtask

  task automatic t_same_edge();
    @(negedge clk); cs_n = 0; wr_n = 0; din = 8'h40; conv_n = 0;
    @(negedge clk); wr_n = 1; conv_n = 1;
    @(posedge clk); #1; run++;
    @(negedge clk); cs_n = 1;
    expect_seq(8'h12, "R3 same-edge write");
    do_start();
    expect_seq(8'h40, "R3 same-edge write later run");
  endtask

  task automatic t_empty();
    write_cfg(8'h00, 1);
    do_start();
    expect_seq(8'h00, "R6 empty");
  endtask

  task automatic t_abort();
    write_cfg(8'hFF, 1);
    do_start();
    repeat (17) @(posedge clk);
    #1 chk(eoc_n == 0 && res_chan == 0, "R8 first result before abort", eoc_n, 0);
    @(negedge clk); conv_n = 0;
    quiet(40, "R8 abort");
    chk(eolc_n == 1, "R8 no eolc after abort", eolc_n, 1);
  endtask

  task automatic t_shdn();
    write_cfg(8'h0C, 1);
    @(negedge clk); shdn = 1;
    do_start();
    quiet(40, "R9 start ignored in shutdown");
    chk(eolc_n == 1, "R9 eolc in shutdown", eolc_n, 1);
    @(negedge clk); shdn = 0;
    do_start();
    expect_seq(8'h0C, "R9 mask kept through shutdown");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_full();
    t_sparse();
    t_midwrite();
    t_nocs();
    t_same_edge();
    t_empty();
    t_abort();
    t_shdn();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule